// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block sits between a simple host request port and an asynchronous DRAM that offers only half as many address pins as its word address needs. A host request carries a full word address. The controller splits it into a row part (upper bits) and a column part (lower bits). It presents the two parts one after the other on the shared address pins. The row is captured by the row strobe and the column by the column strobe. All four control strobes are active low.

A built-in interval timer raises a refresh request every `REF_PERIOD` cycles. A refresh asserts only the row strobe, with the row taken from an internal counter instead of the host address. That restores the charge of one whole row. The counter then steps to the next row and wraps after the last row, so repeated refreshes sweep every row.

A refresh never interrupts a host access. A refresh that is pending wins over the next host request. Read data is captured in the last cycle of the column strobe and returned with a one-cycle valid pulse.

Top module: `mux_dram_ctrl`

## Requirements
- R1: An accepted request at address A drives row A[ROW_W+COL_W-1:COL_W] on the address pins while only the row strobe is low. It drives column A[COL_W-1:0] while the column strobe is low.
- R2: The column strobe falls exactly T_RCD cycles after the row strobe falls, and it is low only while the row strobe is low.
- R3: The column strobe stays low for exactly T_CAS cycles. After every rise of the row strobe, that strobe stays high for at least T_RP cycles before it falls again.
- R4: During a write, write-enable is low for the whole column strobe and the write data is driven with the data-drive enable high. Output-enable stays high, and no response pulse is produced.
- R5: During a read, output-enable is low and write-enable is high for the whole column strobe. The data on the DRAM data inputs in the last column-strobe cycle is returned on rsp_rdata, with rsp_valid high for exactly one cycle.
- R6: A refresh holds the row strobe low for T_RCD+T_CAS cycles, with the refresh counter's row on the address pins. The column strobe stays high throughout.
- R7: The refresh row is 0 after reset and increases by one after each refresh, wrapping from 2^ROW_W-1 to 0.
- R8: The timer requests a refresh every REF_PERIOD cycles. A pending refresh waits for an access in progress and then runs before the next host request is accepted. req_ready is low whenever an access or refresh is in progress.
- R9: After reset all strobes are high, req_ready is high and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DQ_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DQ_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DQ_W | Data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DQ_W | Data from the DRAM |

## Verification
The bench builds the controller with 3 row bits and 3 column bits, T_RCD=2, T_CAS=2, T_RP=1 and REF_PERIOD=40. With this configuration every one of the 64 word addresses can be written and read back against a behavioural memory. The refresh counter also wraps several times within a short run, so the row sequence past the top row is observed. Because the refresh interval is short, refreshes collide with back-to-back host traffic, which exercises the arbitration.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_REF,
      ST_PRE
   } dmc_state_e;
endpackage

// File: rtl/dmc_refresh.sv
module dmc_refresh #(
   parameter int ROW_W      = 11,
   parameter int REF_PERIOD = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_ack,
   input  logic             ref_done,
   output logic             ref_pending,
   output logic [ROW_W-1:0] ref_row
);
   localparam int TW = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;

   initial begin
      assert (REF_PERIOD >= 1) else $error("REF_PERIOD must be at least 1");
      assert (ROW_W >= 1) else $error("ROW_W must be at least 1");
   end

   logic expire;

   generate
      if (REF_PERIOD == 1) begin : g_always
         assign expire = 1'b1;
      end else begin : g_timer
         logic [TW-1:0] tmr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          tmr <= '0;
            else if (tmr == TW'(REF_PERIOD - 1)) tmr <= '0;
            else                                 tmr <= tmr + 1'b1;
         end
         assign expire = (tmr == TW'(REF_PERIOD - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_pending <= 1'b0;
         ref_row     <= '0;
      end else begin
         if (ref_ack) ref_pending <= 1'b0;
         if (expire)  ref_pending <= 1'b1;
         if (ref_done) ref_row <= ref_row + 1'b1;
      end
   end

   // R7: the refresh row only moves right after a finished refresh
   p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_row != $past(ref_row)) |-> $past(ref_done));
endmodule

// File: rtl/dmc_seq.sv
module dmc_seq
   import dmc_pkg::*;
#(
   parameter int ROW_W = 11,
   parameter int COL_W = 11,
   parameter int DQ_W  = 4,
   parameter int T_RCD = 2,
   parameter int T_CAS = 2,
   parameter int T_RP  = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [ROW_W+COL_W-1:0] req_addr,
   input  logic [DQ_W-1:0]        req_wdata,
   output logic                   req_ready,
   input  logic                   ref_pending,
   output logic                   ref_ack,
   output logic                   ref_done,
   output logic                   rsp_valid,
   output logic [DQ_W-1:0]        rsp_rdata,
   output logic                   sel_ref,
   output logic                   sel_row,
   output logic [ROW_W-1:0]       lat_row,
   output logic [COL_W-1:0]       lat_col,
   output logic [DQ_W-1:0]        lat_wdata,
   output logic                   ras_n,
   output logic                   cas_n,
   output logic                   we_n,
   output logic                   oe_n,
   output logic                   dq_oe,
   input  logic [DQ_W-1:0]        dq_in
);
   localparam int TMAX = ((T_RCD + T_CAS) > T_RP) ? (T_RCD + T_CAS) : T_RP;
   localparam int CW   = $clog2(TMAX + 2);

   initial begin
      assert (T_RCD >= 1) else $error("T_RCD must be at least 1");
      assert (T_CAS >= 1) else $error("T_CAS must be at least 1");
      assert (T_RP  >= 1) else $error("T_RP must be at least 1");
   end

   dmc_state_e    state;
   logic [CW-1:0] cnt;
   logic          wr;
   logic          last;

   assign last = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         wr        <= 1'b0;
         lat_row   <= '0;
         lat_col   <= '0;
         lat_wdata <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (ref_pending) begin
                  state <= ST_REF;
                  cnt   <= CW'(T_RCD + T_CAS - 1);
               end else if (req_valid) begin
                  state     <= ST_ROW;
                  cnt       <= CW'(T_RCD - 1);
                  wr        <= req_write;
                  lat_row   <= req_addr[ROW_W+COL_W-1:COL_W];
                  lat_col   <= req_addr[COL_W-1:0];
                  lat_wdata <= req_wdata;
               end
            end
            ST_ROW: begin
               if (last) begin
                  state <= ST_COL;
                  cnt   <= CW'(T_CAS - 1);
               end else cnt <= cnt - 1'b1;
            end
            ST_COL: begin
               if (last) begin
                  state <= ST_PRE;
                  cnt   <= CW'(T_RP - 1);
                  if (!wr) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= dq_in;
                  end
               end else cnt <= cnt - 1'b1;
            end
            ST_REF: begin
               if (last) begin
                  state <= ST_PRE;
                  cnt   <= CW'(T_RP - 1);
               end else cnt <= cnt - 1'b1;
            end
            ST_PRE: begin
               if (last) state <= ST_IDLE;
               else      cnt   <= cnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE) && !ref_pending;
   assign ref_ack   = (state == ST_IDLE) && ref_pending;
   assign ref_done  = (state == ST_REF) && last;
   assign sel_ref   = (state == ST_REF);
   assign sel_row   = (state == ST_ROW);
   assign ras_n     = !((state == ST_ROW) || (state == ST_COL) || (state == ST_REF));
   assign cas_n     = (state != ST_COL);
   assign we_n      = !((state == ST_COL) && wr);
   assign oe_n      = !((state == ST_COL) && !wr);
   assign dq_oe     = (state == ST_COL) && wr;

   // Strobe-width counters kept for the timing properties below
   logic [CW-1:0] ras_lo_cnt, cas_lo_cnt, ras_hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_lo_cnt <= '0;
         cas_lo_cnt <= '0;
         ras_hi_cnt <= CW'(TMAX + 1);
      end else begin
         ras_lo_cnt <= ras_n ? '0 : ((ras_lo_cnt == CW'(TMAX + 1)) ? ras_lo_cnt : ras_lo_cnt + 1'b1);
         cas_lo_cnt <= cas_n ? '0 : ((cas_lo_cnt == CW'(TMAX + 1)) ? cas_lo_cnt : cas_lo_cnt + 1'b1);
         ras_hi_cnt <= !ras_n ? '0 : ((ras_hi_cnt == CW'(TMAX + 1)) ? ras_hi_cnt : ras_hi_cnt + 1'b1);
      end
   end

   p_rcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> (ras_lo_cnt == CW'(T_RCD)));
   p_cas_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_n) |-> (cas_lo_cnt == CW'(T_CAS)));
   p_precharge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (ras_hi_cnt >= CW'(T_RP)));
   p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl #(
   parameter int ROW_W      = 11,
   parameter int COL_W      = 11,
   parameter int DQ_W       = 4,
   parameter int T_RCD      = 2,
   parameter int T_CAS      = 2,
   parameter int T_RP       = 2,
   parameter int REF_PERIOD = 1000,
   localparam int HAW       = ROW_W + COL_W,
   localparam int PAW       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_write,
   input  logic [HAW-1:0]  req_addr,
   input  logic [DQ_W-1:0] req_wdata,
   output logic            rsp_valid,
   output logic [DQ_W-1:0] rsp_rdata,
   output logic [PAW-1:0]  dram_addr,
   output logic            dram_ras_n,
   output logic            dram_cas_n,
   output logic            dram_we_n,
   output logic            dram_oe_n,
   output logic [DQ_W-1:0] dram_dq_out,
   output logic            dram_dq_oe,
   input  logic [DQ_W-1:0] dram_dq_in
);
   logic             ref_pending, ref_ack, ref_done;
   logic [ROW_W-1:0] ref_row, lat_row;
   logic [COL_W-1:0] lat_col;
   logic             sel_ref, sel_row;

   dmc_refresh #(.ROW_W(ROW_W), .REF_PERIOD(REF_PERIOD)) u_refresh (
      .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_done(ref_done),
      .ref_pending(ref_pending), .ref_row(ref_row));

   dmc_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
             .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready),
      .ref_pending(ref_pending), .ref_ack(ref_ack), .ref_done(ref_done),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sel_ref(sel_ref), .sel_row(sel_row),
      .lat_row(lat_row), .lat_col(lat_col), .lat_wdata(dram_dq_out),
      .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
      .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .dq_in(dram_dq_in));

   // Row/column/refresh multiplexer onto the shared pins
   always_comb begin
      if (sel_ref)      dram_addr = PAW'(ref_row);
      else if (sel_row) dram_addr = PAW'(lat_row);
      else              dram_addr = PAW'(lat_col);
   end

   // R8: a request is only taken while no strobe cycle is open
   p_accept_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> (dram_ras_n && dram_cas_n));
   // R6: refresh owns the row strobe alone
   p_ref_no_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pending && !req_ready && dram_ras_n) |=> dram_cas_n);
endmodule

// File: tb/mux_dram_ctrl_test.sv
module mux_dram_ctrl_test;
   localparam int RW = 3, CW = 3, DW = 4;
   localparam int RCD = 2, CASW = 2, RP = 1, PER = 40;
   localparam int NW = 1 << (RW + CW);

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0;
   logic [RW+CW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
   logic [DW-1:0] rsp_rdata, dq_out, dq_in;
   logic [2:0] dram_addr;

   always #2 clk = ~clk;

   mux_dram_ctrl #(.ROW_W(RW), .COL_W(CW), .DQ_W(DW), .T_RCD(RCD), .T_CAS(CASW),
                   .T_RP(RP), .REF_PERIOD(PER)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
      .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
      .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

   int checks = 0, errors = 0, cycles = 0;
   logic [DW-1:0] mem [NW];
   logic [DW-1:0] exp_mem [NW];
   logic [RW-1:0] row_lat = '0, ref_exp = '0;
   logic [CW-1:0] col_lat = '0;
   logic [RW+CW-1:0] cur_addr = '0;
   logic [DW-1:0] cur_wdata = '0;
   logic prev_ras = 1, prev_cas = 1, saw_cas = 0;
   int ras_lo = 0, cas_lo = 0, hi_cnt = 100, ref_seen = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   assign dq_in = (!cas_n && !oe_n) ? mem[{row_lat, col_lat}] : '0;

   // Behavioural DRAM and pin-level timing monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (!ras_n && prev_ras) begin
            chk(hi_cnt >= RP, "R3 precharge", hi_cnt, RP);
            row_lat = dram_addr; ras_lo = 0; saw_cas = 0;
         end
         if (!cas_n && prev_cas) begin
            chk(ras_lo == RCD, "R2 row-to-column delay", ras_lo, RCD);
            col_lat = dram_addr; saw_cas = 1; cas_lo = 0;
            chk({row_lat, col_lat} == cur_addr, "R1 address split", {row_lat, col_lat}, cur_addr);
            if (!we_n) begin
               chk(dq_oe && oe_n && dq_out == cur_wdata, "R4 write pins", dq_out, cur_wdata);
               mem[{row_lat, col_lat}] = dq_out;
            end else begin
               chk(!oe_n && !dq_oe, "R5 read pins", oe_n, 0);
            end
         end
         if (!cas_n) chk(!ras_n, "R2 column inside row", ras_n, 0);
         if (cas_n && !prev_cas) chk(cas_lo == CASW, "R3 column width", cas_lo, CASW);
         if (ras_n && !prev_ras) begin
            if (!saw_cas) begin
               chk(row_lat == ref_exp, "R7 refresh row", row_lat, ref_exp);
               chk(ras_lo == RCD + CASW, "R6 refresh width", ras_lo, RCD + CASW);
               ref_exp = ref_exp + 1'b1;
               ref_seen++;
            end
            hi_cnt = 0;
         end
         if (!ras_n) begin
            ras_lo++;
            chk(!req_ready, "R8 busy not ready", req_ready, 0);
         end else hi_cnt++;
         if (!cas_n) cas_lo++;
         prev_ras = ras_n; prev_cas = cas_n;
      end
   end

   task automatic accept();
      bit rdy;
      do begin
         rdy = req_ready;
         @(negedge clk);
      end while (!rdy);
      req_valid = 0;
   endtask

   task automatic do_write(input int a, input int d);
      cur_addr = a[RW+CW-1:0]; cur_wdata = d[DW-1:0];
      req_addr = cur_addr; req_wdata = cur_wdata; req_write = 1; req_valid = 1;
      exp_mem[a] = d[DW-1:0];
      accept();
      for (int i = 0; i < RCD + CASW + RP + 1; i++) begin
         chk(!rsp_valid, "R4 no response on write", rsp_valid, 0);
         @(negedge clk);
      end
   endtask

   task automatic do_read(input int a);
      int n = 0;
      cur_addr = a[RW+CW-1:0];
      req_addr = cur_addr; req_write = 0; req_valid = 1;
      accept();
      while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
      chk(rsp_valid, "R5 response seen", rsp_valid, 1);
      chk(rsp_rdata == exp_mem[a], "R5 read data", rsp_rdata, exp_mem[a]);
      @(negedge clk);
      chk(!rsp_valid, "R5 one-cycle pulse", rsp_valid, 0);
   endtask

   initial begin
      for (int i = 0; i < NW; i++) begin mem[i] = '0; exp_mem[i] = '0; end
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(ras_n && cas_n && we_n && oe_n, "R9 strobes high", {ras_n, cas_n, we_n, oe_n}, 15);
      chk(req_ready, "R9 ready", req_ready, 1);
      chk(!rsp_valid, "R9 no response", rsp_valid, 0);
      rst_n = 1;
      // R8/R7: idle refresh rate, wrapping the row counter
      repeat (420) @(negedge clk);
      chk(ref_seen == 10, "R8 refresh rate", ref_seen, 10);
      // Full sweep: write then read every word
      for (int a = 0; a < NW; a++) do_write(a, (a * 7 + 3) & 15);
      for (int a = 0; a < NW; a++) do_read(a);
      // Second pattern: inverted, descending writes, then read back
      for (int a = NW - 1; a >= 0; a--) do_write(a, (~(a * 5)) & 15);
      for (int a = 0; a < NW; a++) do_read(a);
      // Back-to-back write/read on single addresses
      for (int a = 0; a < NW; a += 9) begin do_write(a, a & 15); do_read(a); end
      chk(ref_seen > 20, "R8 refresh not starved", ref_seen, 21);
      repeat (10) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule